// File: doc/BRIEF.md
# Character Display Controller Register Model

This block models the device side of a character display controller as a host sees it over an 8-bit parallel bus. The host drives an enable strobe, a register-select line and a read/write line. The model decodes each access on the falling edge of the strobe. Register select low with write carries an instruction. Register select low with read returns the busy flag and the address counter. Register select high moves a byte between the host and either the 80-byte display memory or the 64-byte glyph memory. Both memories share one 7-bit address counter.

Each instruction or memory access that the model accepts starts an execution interval. The busy flag stays high for the whole interval. The length of each interval comes from a clock-frequency parameter given in kHz. Clear and home take 1.64 ms. Every other instruction and every memory access takes 40 us. While the flag is high, the model drops any access other than a status read. The counter steps up or down after each memory access, depending on the direction bit that the entry-mode instruction sets.

Top module: `chlcd_regmodel`

## Requirements
- R1: After reset the busy flag is 0, the address counter is 0, display memory is the access target and the counter steps upward.
- R2: A status read (select 0, read 1) returns the busy flag on bit 7 and the address counter on bits 6..0. The output enable is high only while the strobe is high and read is selected. Otherwise the output enable is low and the data output is 0x00.
- R3: A data write (select 1, write) stores the byte in display memory at the address counter, and the counter then steps.
- R4: The entry-mode instruction 0b000001DS sets the step direction from bit 1 (D): 1 increments, 0 decrements. Bit 0 has no effect.
- R5: In display memory the counter wraps from 79 up to 0 and from 0 down to 79.
- R6: The set-display-address instruction 1AAAAAAA loads the 7-bit value A into the counter and selects display memory.
- R7: The set-glyph-address instruction 01AAAAAA loads the 6-bit value A and selects glyph memory. Data accesses then go to glyph memory, and the counter wraps within 6 bits (63 to 0, 0 to 63). This lasts until set-display-address, clear or home.
- R8: Clear (0x01) sets all 80 display bytes to 0x20, sets the counter to 0 and selects display memory.
- R9: Home (0b0000001x) sets the counter to 0 and selects display memory. Display bytes are left unchanged.
- R10: Clear and home hold busy for ceil(CLK_KHZ*1640/1000) clocks. Every other nonzero instruction and every data read or write holds busy for ceil(CLK_KHZ*40/1000) clocks. A status read and the byte 0x00 start no interval.
- R11: While busy is 1, instructions and data accesses have no effect on the counter, the memories or the direction.
- R12: A data read returns the byte at the counter in the selected memory and then steps the counter. A display address of 80 or above reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lcd_en | input | 1 | Access strobe; an access takes effect on its falling edge |
| lcd_sel_data | input | 1 | 0: instruction/status, 1: memory data |
| lcd_read | input | 1 | 1: read, 0: write |
| lcd_din | input | 8 | Byte from host |
| lcd_dout | output | 8 | Byte to host, valid while lcd_doe is high |
| lcd_doe | output | 1 | Output enable for the bidirectional bus pad |

## Verification
The hardest case to reach from the ports is an access that arrives while an execution interval is still running: the model must drop it and leave no trace. To get there, the bench issues a clear and, in the cycles right after it, an address load and a data write. Once the long interval has ended, it reads back the counter and the display byte to confirm that neither changed. The length of each interval is measured by holding a status read open and counting the cycles in which bit 7 is set. The counter wrap points are reached by filling all 80 display cells, by stepping down from address 0 in decrement mode, and by loading glyph address 62 and writing past it.

// File: rtl/chlcd_pkg.sv
package chlcd_pkg;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_CLEAR,
    OP_HOME,
    OP_ENTRY,
    OP_CTRL,
    OP_SHIFT,
    OP_FUNC,
    OP_SET_GLYPH,
    OP_SET_DISP
  } op_e;

  typedef struct packed {
    logic       valid;
    logic       sel_data;
    logic       read;
    logic [7:0] data;
  } bus_evt_t;

  localparam logic [7:0] BLANK_CODE = 8'h20;

  // The leading one decides the instruction, so bit positions are fixed.
  function automatic op_e decode_op(input logic [7:0] b);
    op_e o;
    casez (b)
      8'b1???????: o = OP_SET_DISP;
      8'b01??????: o = OP_SET_GLYPH;
      8'b001?????: o = OP_FUNC;
      8'b0001????: o = OP_SHIFT;
      8'b00001???: o = OP_CTRL;
      8'b000001??: o = OP_ENTRY;
      8'b0000001?: o = OP_HOME;
      8'b00000001: o = OP_CLEAR;
      default:     o = OP_NONE;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/chlcd_bus_sampler.sv
module chlcd_bus_sampler
  import chlcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       sel_data_i,
  input  logic       read_i,
  input  logic [7:0] din_i,
  output bus_evt_t   evt_o
);

  logic       en_q, en_n;
  logic       sel_q, sel_n;
  logic       rd_q, rd_n;
  logic [7:0] dat_q, dat_n;

  always_comb begin
    en_n  = en_i;
    sel_n = sel_q;
    rd_n  = rd_q;
    dat_n = dat_q;
    if (en_i) begin
      sel_n = sel_data_i;
      rd_n  = read_i;
      dat_n = din_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= 1'b0;
      rd_q  <= 1'b0;
      dat_q <= 8'h00;
    end else begin
      en_q  <= en_n;
      sel_q <= sel_n;
      rd_q  <= rd_n;
      dat_q <= dat_n;
    end
  end

  always_comb begin
    evt_o.valid    = en_q && !en_i;
    evt_o.sel_data = sel_q;
    evt_o.read     = rd_q;
    evt_o.data     = dat_q;
  end

endmodule

// File: rtl/chlcd_busy_timer.sv
module chlcd_busy_timer #(
  parameter int LONG_CYC  = 82000,
  parameter int SHORT_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_long_i,
  input  logic start_short_i,
  output logic busy_o
);

  localparam int CW = (LONG_CYC > SHORT_CYC) ? $clog2(LONG_CYC + 1) : $clog2(SHORT_CYC + 1);

  logic          busy_q, busy_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    if (start_long_i) begin
      busy_n = 1'b1;
      cnt_n  = CW'(LONG_CYC - 1);
    end else if (start_short_i) begin
      busy_n = 1'b1;
      cnt_n  = CW'(SHORT_CYC - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_n = 1'b0;
      else             cnt_n  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
    end
  end

  assign busy_o = busy_q;

  AST_BUSY_ENDS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == '0) |=> !busy_q); // R10
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !(start_long_i || start_short_i)); // R11

endmodule

// File: rtl/chlcd_store.sv
module chlcd_store
  import chlcd_pkg::*;
#(
  parameter int DISP_DEPTH  = 80,
  parameter int GLYPH_DEPTH = 64,
  parameter int AW          = 7
) (
  input  logic          clk,
  input  logic          clear_i,
  input  logic          wr_disp_i,
  input  logic          wr_glyph_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  input  logic          glyph_sel_i,
  output logic [7:0]    rdata_o
);

  localparam int GAW = $clog2(GLYPH_DEPTH);
  localparam logic [AW-1:0] DISP_END = AW'(DISP_DEPTH);

  logic [7:0] disp_q  [DISP_DEPTH];
  logic [7:0] glyph_q [GLYPH_DEPTH];
  logic       in_disp;

  assign in_disp = addr_i < DISP_END;

  always_ff @(posedge clk) begin
    if (clear_i) begin
      for (int i = 0; i < DISP_DEPTH; i++) disp_q[i] <= BLANK_CODE;
    end else if (wr_disp_i && in_disp) begin
      disp_q[addr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_glyph_i) glyph_q[addr_i[GAW-1:0]] <= wdata_i;
  end

  always_comb begin
    if (glyph_sel_i)  rdata_o = glyph_q[addr_i[GAW-1:0]];
    else if (in_disp) rdata_o = disp_q[addr_i];
    else              rdata_o = 8'h00;
  end

endmodule

// File: rtl/chlcd_regmodel.sv
module chlcd_regmodel
  import chlcd_pkg::*;
#(
  parameter int CLK_KHZ     = 50000,
  parameter int DISP_DEPTH  = 80,
  parameter int GLYPH_DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lcd_en,
  input  logic       lcd_sel_data,
  input  logic       lcd_read,
  input  logic [7:0] lcd_din,
  output logic [7:0] lcd_dout,
  output logic       lcd_doe
);

  localparam int AW        = 7;
  localparam int GAW       = $clog2(GLYPH_DEPTH);
  localparam int LONG_RAW  = (CLK_KHZ * 1640 + 999) / 1000;
  localparam int SHORT_RAW = (CLK_KHZ * 40 + 999) / 1000;
  localparam int LONG_CYC  = (LONG_RAW < 1) ? 1 : LONG_RAW;
  localparam int SHORT_CYC = (SHORT_RAW < 1) ? 1 : SHORT_RAW;
  localparam logic [AW-1:0] DISP_LAST = AW'(DISP_DEPTH - 1);
  localparam logic [AW-1:0] GLYPH_MASK = AW'((1 << GAW) - 1);

  bus_evt_t      evt;
  logic          busy;
  logic          accept, is_instr, is_data;
  op_e           op;
  logic [AW-1:0] ac_q, ac_n, ac_step;
  logic          up_q, up_n;
  logic          glyph_q, glyph_n;
  logic          start_long, start_short, clr_disp, wr_disp, wr_glyph;
  logic [7:0]    rdata;
  logic          drive;

  chlcd_bus_sampler u_sampler (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (lcd_en),
    .sel_data_i (lcd_sel_data),
    .read_i     (lcd_read),
    .din_i      (lcd_din),
    .evt_o      (evt)
  );

  chlcd_busy_timer #(
    .LONG_CYC  (LONG_CYC),
    .SHORT_CYC (SHORT_CYC)
  ) u_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_long_i  (start_long),
    .start_short_i (start_short),
    .busy_o        (busy)
  );

  chlcd_store #(
    .DISP_DEPTH  (DISP_DEPTH),
    .GLYPH_DEPTH (GLYPH_DEPTH),
    .AW          (AW)
  ) u_store (
    .clk         (clk),
    .clear_i     (clr_disp),
    .wr_disp_i   (wr_disp),
    .wr_glyph_i  (wr_glyph),
    .addr_i      (ac_q),
    .wdata_i     (evt.data),
    .glyph_sel_i (glyph_q),
    .rdata_o     (rdata)
  );

  assign accept   = evt.valid && !busy;
  assign is_instr = accept && !evt.sel_data && !evt.read;
  assign is_data  = accept && evt.sel_data;
  assign op       = decode_op(evt.data);

  // Address step after a memory access; glyph space wraps in GAW bits,
  // display space wraps at its last cell.
  always_comb begin
    if (glyph_q) begin
      ac_step = (up_q ? ac_q + 1'b1 : ac_q - 1'b1) & GLYPH_MASK;
    end else if (up_q) begin
      ac_step = (ac_q >= DISP_LAST) ? '0 : ac_q + 1'b1;
    end else begin
      ac_step = (ac_q == '0) ? DISP_LAST : ac_q - 1'b1;
    end
  end

  always_comb begin
    ac_n        = ac_q;
    up_n        = up_q;
    glyph_n     = glyph_q;
    start_long  = 1'b0;
    start_short = 1'b0;
    clr_disp    = 1'b0;
    wr_disp     = 1'b0;
    wr_glyph    = 1'b0;
    if (is_instr) begin
      case (op)
        OP_CLEAR: begin
          clr_disp   = 1'b1;
          ac_n       = '0;
          glyph_n    = 1'b0;
          start_long = 1'b1;
        end
        OP_HOME: begin
          ac_n       = '0;
          glyph_n    = 1'b0;
          start_long = 1'b1;
        end
        OP_ENTRY: begin
          up_n        = evt.data[1];
          start_short = 1'b1;
        end
        OP_CTRL, OP_SHIFT, OP_FUNC: begin
          start_short = 1'b1;
        end
        OP_SET_GLYPH: begin
          ac_n        = AW'(evt.data[GAW-1:0]);
          glyph_n     = 1'b1;
          start_short = 1'b1;
        end
        OP_SET_DISP: begin
          ac_n        = evt.data[AW-1:0];
          glyph_n     = 1'b0;
          start_short = 1'b1;
        end
        default: ;
      endcase
    end else if (is_data) begin
      wr_disp     = !evt.read && !glyph_q;
      wr_glyph    = !evt.read && glyph_q;
      ac_n        = ac_step;
      start_short = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q    <= '0;
      up_q    <= 1'b1;
      glyph_q <= 1'b0;
    end else begin
      ac_q    <= ac_n;
      up_q    <= up_n;
      glyph_q <= glyph_n;
    end
  end

  assign drive    = lcd_en && lcd_read;
  assign lcd_doe  = drive;
  assign lcd_dout = !drive ? 8'h00 : (lcd_sel_data ? rdata : {busy, ac_q});

  AST_BUSY_FREEZES_AC: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ac_q)); // R11
  AST_GLYPH_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    glyph_q |-> ((ac_q & ~GLYPH_MASK) == '0)); // R7
  AST_DISP_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (is_data && !glyph_q && up_q && ac_q == DISP_LAST) |=> (ac_q == '0)); // R5
  AST_CLEAR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (is_instr && op == OP_CLEAR) |=> (ac_q == '0 && busy && !glyph_q)); // R8

endmodule

// File: tb/tb_chlcd_regmodel.sv
module tb_chlcd_regmodel;

  localparam int CLK_PERIOD = 10;
  localparam int KHZ   = 100;
  localparam int LONG  = (KHZ * 1640 + 999) / 1000;
  localparam int SHORT = (KHZ * 40 + 999) / 1000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en, sel, rd;
  logic [7:0] din;
  logic [7:0] dout;
  logic       doe;

  int n_chk  = 0;
  int n_fail = 0;

  chlcd_regmodel #(.CLK_KHZ(KHZ)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .lcd_en       (en),
    .lcd_sel_data (sel),
    .lcd_read     (rd),
    .lcd_din      (din),
    .lcd_dout     (dout),
    .lcd_doe      (doe)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic bus_wr(input logic s, input logic [7:0] d);
    @(negedge clk);
    sel = s; rd = 1'b0; din = d; en = 1'b1;
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic s, output logic [7:0] v, output logic oe);
    @(negedge clk);
    sel = s; rd = 1'b1; en = 1'b1;
    #1;
    v = dout; oe = doe;
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
  endtask

  // Holds a status read open right after an access and counts busy cycles.
  task automatic measure_busy(output int n);
    sel = 1'b0; rd = 1'b1; en = 1'b1;
    #1;
    n = 0;
    while (dout[7] && n < 1000) begin
      n++;
      @(negedge clk);
      #1;
    end
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic instr(input logic [7:0] d);
    bus_wr(1'b0, d);
    repeat ((d == 8'h01 || d[7:1] == 7'h01) ? LONG + 1 : SHORT + 1) @(negedge clk);
  endtask

  task automatic dwr(input logic [7:0] d);
    bus_wr(1'b1, d);
    repeat (SHORT + 1) @(negedge clk);
  endtask

  task automatic drd(output logic [7:0] v);
    logic oe;
    bus_rd(1'b1, v, oe);
    repeat (SHORT + 1) @(negedge clk);
  endtask

  task automatic status(output logic [7:0] v);
    logic oe;
    bus_rd(1'b0, v, oe);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [7:0] v;
    logic       oe;
    int         n;
    int         bad;
    en = 1'b0; sel = 1'b0; rd = 1'b0; din = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2: reset state and output enable
    bus_rd(1'b0, v, oe);
    chk("R1 status after reset", v, 8'h00);
    chk("R2 oe during read", oe, 1'b1);
    chk("R2 oe idle", doe, 1'b0);
    chk("R2 dout idle", dout, 8'h00);
    @(negedge clk);
    sel = 1'b0; rd = 1'b0; en = 1'b1; din = 8'h00;
    #1 chk("R2 oe during write strobe", doe, 1'b0);
    @(negedge clk);
    rd = 1'b1; en = 1'b0;
    #1 chk("R2 oe read without strobe", doe, 1'b0);
    @(negedge clk);

    // R10: busy lengths
    bus_wr(1'b0, 8'h01);
    measure_busy(n);
    chk("R10 clear busy cycles", n, LONG);
    bus_wr(1'b0, 8'h80);
    measure_busy(n);
    chk("R10 set address busy cycles", n, SHORT);
    bus_wr(1'b1, 8'h42);
    measure_busy(n);
    chk("R10 data write busy cycles", n, SHORT);
    bus_wr(1'b0, 8'h00);
    measure_busy(n);
    chk("R10 zero byte starts no busy", n, 0);

    // R3 / R5 / R12: fill all display cells with increment, wrap, read back
    instr(8'h80);
    for (int i = 0; i < 80; i++) dwr(8'((i * 7 + 3) & 8'hFF));
    status(v);
    chk("R5 increment wrap 79 to 0", v, 8'h00);
    bad = 0;
    for (int i = 0; i < 80; i++) begin
      drd(v);
      if (v !== 8'((i * 7 + 3) & 8'hFF)) bad++;
    end
    chk("R3 R12 display readback mismatches", bad, 0);
    status(v);
    chk("R12 read steps counter", v, 8'h00);
    instr(8'h80 | 8'd85);
    drd(v);
    chk("R12 address beyond 79 reads zero", v, 8'h00);

    // R4 / R5: decrement mode, bit 0 ignored
    instr(8'h05);
    instr(8'h80);
    dwr(8'hAA);
    status(v);
    chk("R5 decrement wrap 0 to 79", v, 8'd79);
    dwr(8'hBB);
    status(v);
    chk("R4 decrement step", v, 8'd78);
    instr(8'h80 | 8'd79);
    drd(v);
    chk("R4 byte at 79", v, 8'hBB);
    instr(8'h06);

    // R9: home keeps memory
    instr(8'h80 | 8'd40);
    bus_wr(1'b0, 8'h03);
    measure_busy(n);
    chk("R9 home busy cycles", n, LONG);
    status(v);
    chk("R9 home counter", v, 8'h00);
    drd(v);
    chk("R9 home keeps display byte 0", v, 8'hAA);

    // R8: clear fills blanks
    instr(8'h01);
    status(v);
    chk("R8 clear counter", v, 8'h00);
    bad = 0;
    for (int i = 0; i < 80; i++) begin
      drd(v);
      if (v !== 8'h20) bad++;
    end
    chk("R8 non-blank cells after clear", bad, 0);

    // R7: glyph memory and 6-bit wrap
    instr(8'h40 | 8'd62);
    dwr(8'h11);
    dwr(8'h12);
    dwr(8'h13);
    status(v);
    chk("R7 glyph counter wrap 63 to 0", v, 8'h01);
    instr(8'h40 | 8'd62);
    drd(v);
    chk("R7 glyph byte 62", v, 8'h11);
    instr(8'h40);
    for (int i = 0; i < 64; i++) dwr(8'((i * 13 + 5) & 8'hFF));
    instr(8'h40);
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      drd(v);
      if (v !== 8'((i * 13 + 5) & 8'hFF)) bad++;
    end
    chk("R7 glyph readback mismatches", bad, 0);
    instr(8'h04);
    instr(8'h40);
    dwr(8'h77);
    status(v);
    chk("R7 glyph decrement wrap 0 to 63", v, 8'd63);
    instr(8'h06);

    // R6: display address ends glyph redirect
    instr(8'h80 | 8'd5);
    drd(v);
    chk("R6 display byte after glyph mode", v, 8'h20);
    status(v);
    chk("R6 counter after display read", v, 8'd6);

    // R11: accesses during busy dropped
    bus_wr(1'b0, 8'h01);
    bus_wr(1'b0, 8'h90);
    bus_wr(1'b1, 8'h55);
    bus_wr(1'b0, 8'h04);
    repeat (LONG + 2) @(negedge clk);
    status(v);
    chk("R11 counter unchanged by busy accesses", v, 8'h00);
    drd(v);
    chk("R11 display byte unchanged", v, 8'h20);
    status(v);
    chk("R11 direction unchanged", v, 8'h01);
    status(v);
    chk("R2 status read has no side effect", v, 8'h01);

    summary();
  end

endmodule